// File: doc/BRIEF.md
# Vector Type Legality Checker

This block judges one vector configuration request at a time: an element-width code, a register-grouping code (whole or fractional grouping), an application vector length, and the index of the first register in a group. From the build-time register width `VLEN` and largest element width `ELEN` it works out whether the width/grouping pair is allowed. It also works out how many elements one grouped register holds at most, and how many of the requested elements are granted.

A separate flag reports whether the register index suits the group size. The result is stored in one output register and shows up one clock after the request. An illegal pair raises the illegal flag and clears both lengths to zero, so a following stage never sees a non-zero length under a rejected type. The defaults are `VLEN` = 128 and `ELEN` = 32.

Top module: `vtype_check`

## Requirements
- R1: After reset, `resValid` is 0, `vlmax` and `grantedVl` are 0, `illegal` is 1 and `alignErr` is 0.
- R2: A request taken with `reqValid` high gives its results on the next clock edge, with `resValid` high for that one cycle. While `reqValid` is low, `resValid` is 0 and the result outputs hold their last values.
- R3: The element width is 8 shifted left by `sewCode`. A `sewCode` above log2(ELEN/8) is illegal, which is codes 3 to 7 for ELEN = 32.
- R4: `lmulCode` 000, 001, 010 and 011 select groups of 1, 2, 4 and 8 registers. Codes 101, 110 and 111 select 1/8, 1/4 and 1/2 of a register. Code 100 is reserved and always illegal.
- R5: A fractional grouping is legal only when the element width is at most ELEN times the fraction. With ELEN = 32, 1/8 is illegal for every width, 1/4 allows only 8-bit elements, and 1/2 allows 8-bit or 16-bit elements.
- R6: For a legal pair, `vlmax` equals the grouping factor times VLEN divided by the element width.
- R7: For a legal pair, `grantedVl` is the smaller of `avl` and `vlmax`.
- R8: For an illegal pair, `illegal` is 1 and `vlmax`, `grantedVl` and `alignErr` are all 0.
- R9: For a legal whole-register grouping, `alignErr` is 1 exactly when `regIdx` is not a multiple of the group size. For example, a group of 8 accepts only registers 0, 8, 16 and 24. A fractional grouping never sets `alignErr`. `alignErr` does not change `illegal` or either length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe; inputs below are sampled when high |
| sewCode | input | 3 | Element width code |
| lmulCode | input | 3 | Register grouping code |
| avl | input | 16 | Application-requested element count |
| regIdx | input | 5 | First register of the operand group |
| resValid | output | 1 | One-cycle pulse marking fresh results |
| vlmax | output | 8 | Maximum elements for the accepted type |
| grantedVl | output | 8 | Granted element count |
| illegal | output | 1 | Type rejected |
| alignErr | output | 1 | Register index not aligned to group size |

## Verification
The assertions on the decode take the width and grouping codes as valid at every sampled edge. They take `reqValid` as a known 0 or 1 from reset on. The bench drives all inputs to defined values before reset is released and changes them only at falling edges. The bound check on `grantedVl` relies on `avl` being at least as wide as `vlmax`, which holds for the default widths. Directed scenarios cover the ELEN = 32 fraction corners and the aligned and misaligned indices. A sweep then walks all 64 code pairs against a model built from the requirements.

// File: rtl/vtype_pkg.sv
package vtype_pkg;

  // Strobes and decoded fields handed from control to datapath
  typedef struct packed {
    logic       load;       // capture a new result this cycle
    logic       legal;      // width/grouping pair accepted
    logic [2:0] sewLog;     // log2(SEW/8)
    logic [1:0] grpLog;     // log2 of whole-register group size
    logic [1:0] fracLog;    // log2 of fractional divisor, 0 when whole
    logic       misaligned; // group start not on a group boundary
  } vtype_ctrl_t;

  localparam logic [2:0] LMUL_RESERVED = 3'b100;

endpackage

// File: rtl/vtype_ctrl.sv
module vtype_ctrl
  import vtype_pkg::*;
#(
  parameter int ELEN  = 32,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [2:0]       sewCode,
  input  logic [2:0]       lmulCode,
  input  logic [REG_W-1:0] regIdx,
  output vtype_ctrl_t      ctrlOut
);

  localparam int MAX_SEW_CODE = $clog2(ELEN) - 3;

  logic             isReserved;
  logic             isFrac;
  logic [1:0]       fracLog;
  logic [1:0]       grpLog;
  logic             sewOk;
  logic             fracOk;
  logic             legal;
  logic [REG_W-1:0] grpMask;

  always_comb begin
    isReserved = (lmulCode == LMUL_RESERVED);
    isFrac     = lmulCode[2] && !isReserved;
    grpLog     = isFrac ? 2'd0 : lmulCode[1:0];
    unique case (lmulCode)
      3'b101:  fracLog = 2'd3;
      3'b110:  fracLog = 2'd2;
      3'b111:  fracLog = 2'd1;
      default: fracLog = 2'd0;
    endcase
    sewOk   = int'(sewCode) <= MAX_SEW_CODE;
    fracOk  = (int'(sewCode) + int'(fracLog)) <= MAX_SEW_CODE;
    legal   = !isReserved && sewOk && fracOk;
    grpMask = REG_W'((1 << grpLog) - 1);
  end

  always_comb begin
    ctrlOut.load       = reqValid;
    ctrlOut.legal      = legal;
    ctrlOut.sewLog     = sewCode;
    ctrlOut.grpLog     = grpLog;
    ctrlOut.fracLog    = fracLog;
    ctrlOut.misaligned = legal && !isFrac && ((regIdx & grpMask) != '0);
  end

  // R4: reserved grouping code is never accepted
  p_reserved_rejected_r4: assert property (@(posedge clk) disable iff (!rstN)
    (lmulCode == LMUL_RESERVED) |-> !ctrlOut.legal);

  // R3: element width beyond ELEN is never accepted
  p_wide_sew_rejected_r3: assert property (@(posedge clk) disable iff (!rstN)
    (int'(sewCode) > MAX_SEW_CODE) |-> !ctrlOut.legal);

  // R9: fractional grouping never flags alignment
  p_frac_aligned_r9: assert property (@(posedge clk) disable iff (!rstN)
    (lmulCode[2]) |-> !ctrlOut.misaligned);

endmodule

// File: rtl/vtype_dp.sv
module vtype_dp
  import vtype_pkg::*;
#(
  parameter int VLEN  = 128,
  parameter int AVL_W = 16,
  parameter int VL_W  = $clog2(VLEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  vtype_ctrl_t      ctrlIn,
  input  logic [AVL_W-1:0] avl,
  output logic             resValid,
  output logic [VL_W-1:0]  vlmax,
  output logic [VL_W-1:0]  grantedVl,
  output logic             illegal,
  output logic             alignErr
);

  localparam int WIDE_W = $clog2(VLEN) + 4;

  logic [WIDE_W-1:0] scaled;
  logic [VL_W-1:0]   maxNext;
  logic [VL_W-1:0]   grantNext;
  logic [AVL_W-1:0]  maxWide;

  always_comb begin
    scaled    = WIDE_W'(VLEN) << ctrlIn.grpLog;
    scaled    = scaled >> (4'd3 + 4'(ctrlIn.sewLog) + 4'(ctrlIn.fracLog));
    maxNext   = ctrlIn.legal ? VL_W'(scaled) : '0;
    maxWide   = AVL_W'(maxNext);
    grantNext = (avl < maxWide) ? VL_W'(avl) : maxNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      vlmax     <= '0;
      grantedVl <= '0;
      illegal   <= 1'b1;
      alignErr  <= 1'b0;
    end else begin
      resValid <= ctrlIn.load;
      if (ctrlIn.load) begin
        vlmax     <= maxNext;
        grantedVl <= grantNext;
        illegal   <= !ctrlIn.legal;
        alignErr  <= ctrlIn.misaligned;
      end
    end
  end

  // R7: granted length never exceeds the maximum
  p_grant_bounded_r7: assert property (@(posedge clk) disable iff (!rstN)
    grantedVl <= vlmax);

  // R8: a rejected type carries no length and no alignment flag
  p_illegal_zeroes_r8: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (vlmax == '0 && grantedVl == '0 && !alignErr));

  // R2: one-cycle latency of the valid pulse
  p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctrlIn.load |=> resValid);

  // R2: idle cycles hold results and keep valid low
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlIn.load |=> (!resValid && $stable(vlmax) && $stable(grantedVl) && $stable(illegal)));

endmodule

// File: rtl/vtype_check.sv
module vtype_check
  import vtype_pkg::*;
#(
  parameter int VLEN  = 128,
  parameter int ELEN  = 32,
  parameter int AVL_W = 16,
  parameter int REG_W = 5,
  parameter int VL_W  = $clog2(VLEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [2:0]       sewCode,
  input  logic [2:0]       lmulCode,
  input  logic [AVL_W-1:0] avl,
  input  logic [REG_W-1:0] regIdx,
  output logic             resValid,
  output logic [VL_W-1:0]  vlmax,
  output logic [VL_W-1:0]  grantedVl,
  output logic             illegal,
  output logic             alignErr
);

  vtype_ctrl_t ctrlBus;

  vtype_ctrl #(.ELEN(ELEN), .REG_W(REG_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .sewCode  (sewCode),
    .lmulCode (lmulCode),
    .regIdx   (regIdx),
    .ctrlOut  (ctrlBus)
  );

  vtype_dp #(.VLEN(VLEN), .AVL_W(AVL_W), .VL_W(VL_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlIn    (ctrlBus),
    .avl       (avl),
    .resValid  (resValid),
    .vlmax     (vlmax),
    .grantedVl (grantedVl),
    .illegal   (illegal),
    .alignErr  (alignErr)
  );

endmodule

// File: tb/sim_vtype_check.sv
module sim_vtype_check;

  localparam int CLK_PERIOD = 10;
  localparam int VLEN = 128;
  localparam int ELEN = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  sewCode = 3'd0;
  logic [2:0]  lmulCode = 3'd0;
  logic [15:0] avl = 16'd0;
  logic [4:0]  regIdx = 5'd0;
  logic        resValid;
  logic [7:0]  vlmax;
  logic [7:0]  grantedVl;
  logic        illegal;
  logic        alignErr;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vtype_check #(.VLEN(VLEN), .ELEN(ELEN)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .sewCode(sewCode),
    .lmulCode(lmulCode), .avl(avl), .regIdx(regIdx), .resValid(resValid),
    .vlmax(vlmax), .grantedVl(grantedVl), .illegal(illegal), .alignErr(alignErr)
  );

  task automatic check(input string tag, input int actual, input int expected);
    testCount++;
    if (actual != expected) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  // Request issued at a falling edge, results read at the next falling edge
  task automatic issue(input logic [2:0] s, input logic [2:0] l,
                       input logic [15:0] a, input logic [4:0] r);
    @(negedge clk);
    sewCode = s; lmulCode = l; avl = a; regIdx = r; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // Expected values from the requirements
  task automatic model(input logic [2:0] s, input logic [2:0] l, input int a,
                       input int r, output int eMax, output int eGrant,
                       output int eIll, output int eAlign);
    int frac = (l == 3'b101) ? 3 : (l == 3'b110) ? 2 : (l == 3'b111) ? 1 : 0;
    bit isFrac = (frac != 0);
    int grp = isFrac ? 1 : (1 << l[1:0]);
    int maxSew = $clog2(ELEN) - 3;
    bit ok = (l != 3'b100) && (int'(s) <= maxSew) && (int'(s) + frac <= maxSew);
    if (!ok) begin
      eMax = 0; eGrant = 0; eIll = 1; eAlign = 0;
    end else begin
      eMax = isFrac ? ((VLEN / (8 << s)) >> frac) : (grp * VLEN / (8 << s));
      eGrant = (a < eMax) ? a : eMax;
      eIll = 0;
      eAlign = (!isFrac && (r % grp) != 0) ? 1 : 0;
    end
  endtask

  task automatic expectAll(input string tag, input int eMax, input int eGrant,
                           input int eIll, input int eAlign);
    check({tag, " resValid"}, int'(resValid), 1);
    check({tag, " vlmax"}, int'(vlmax), eMax);
    check({tag, " grantedVl"}, int'(grantedVl), eGrant);
    check({tag, " illegal"}, int'(illegal), eIll);
    check({tag, " alignErr"}, int'(alignErr), eAlign);
  endtask

  task automatic testReset();
    check("R1 resValid", int'(resValid), 0);
    check("R1 vlmax", int'(vlmax), 0);
    check("R1 grantedVl", int'(grantedVl), 0);
    check("R1 illegal", int'(illegal), 1);
    check("R1 alignErr", int'(alignErr), 0);
  endtask

  task automatic testWholeGroups();
    issue(3'd0, 3'b000, 16'd1000, 5'd0); expectAll("R6 e8 m1", 16, 16, 0, 0);
    issue(3'd2, 3'b011, 16'd1000, 5'd8); expectAll("R6 e32 m8", 32, 32, 0, 0);
    issue(3'd0, 3'b011, 16'd500, 5'd16); expectAll("R6 e8 m8", 128, 128, 0, 0);
    issue(3'd1, 3'b001, 16'd1000, 5'd2); expectAll("R4 e16 m2", 16, 16, 0, 0);
  endtask

  task automatic testGrant();
    issue(3'd0, 3'b000, 16'd5, 5'd0);  expectAll("R7 avl below", 16, 5, 0, 0);
    issue(3'd0, 3'b000, 16'd16, 5'd0); expectAll("R7 avl equal", 16, 16, 0, 0);
    issue(3'd0, 3'b000, 16'd0, 5'd0);  expectAll("R7 avl zero", 16, 0, 0, 0);
  endtask

  task automatic testFractions();
    issue(3'd1, 3'b111, 16'd100, 5'd7); expectAll("R5 e16 mf2", 4, 4, 0, 0);
    issue(3'd0, 3'b110, 16'd100, 5'd3); expectAll("R5 e8 mf4", 4, 4, 0, 0);
    issue(3'd1, 3'b110, 16'd100, 5'd0); expectAll("R5 e16 mf4", 0, 0, 1, 0);
    issue(3'd0, 3'b101, 16'd100, 5'd0); expectAll("R5 e8 mf8", 0, 0, 1, 0);
    issue(3'd2, 3'b111, 16'd100, 5'd0); expectAll("R5 e32 mf2", 0, 0, 1, 0);
  endtask

  task automatic testIllegalCodes();
    issue(3'd3, 3'b000, 16'd10, 5'd0); expectAll("R3 e64", 0, 0, 1, 0);
    issue(3'd7, 3'b000, 16'd10, 5'd0); expectAll("R3 code7", 0, 0, 1, 0);
    issue(3'd0, 3'b100, 16'd10, 5'd0); expectAll("R4 reserved", 0, 0, 1, 0);
    issue(3'd0, 3'b100, 16'd10, 5'd3); expectAll("R8 no align flag", 0, 0, 1, 0);
  endtask

  task automatic testAlignment();
    issue(3'd0, 3'b011, 16'd10, 5'd24); expectAll("R9 m8 v24", 128, 10, 0, 0);
    issue(3'd0, 3'b011, 16'd10, 5'd12); expectAll("R9 m8 v12", 128, 10, 0, 1);
    issue(3'd0, 3'b001, 16'd10, 5'd3);  expectAll("R9 m2 v3", 32, 10, 0, 1);
    issue(3'd0, 3'b010, 16'd10, 5'd6);  expectAll("R9 m4 v6", 64, 10, 0, 1);
    issue(3'd0, 3'b111, 16'd10, 5'd31); expectAll("R9 mf2 v31", 8, 8, 0, 0);
  endtask

  task automatic testHold();
    issue(3'd1, 3'b010, 16'd9, 5'd4);
    expectAll("R2 fresh", 32, 9, 0, 0);
    @(negedge clk);
    sewCode = 3'd3; lmulCode = 3'b100; avl = 16'd1;
    @(negedge clk);
    check("R2 valid low", int'(resValid), 0);
    check("R2 vlmax held", int'(vlmax), 32);
    check("R2 grant held", int'(grantedVl), 9);
    check("R2 illegal held", int'(illegal), 0);
  endtask

  task automatic testSweep();
    for (int s = 0; s < 8; s++) begin
      for (int l = 0; l < 8; l++) begin
        int eMax, eGrant, eIll, eAlign;
        model(3'(s), 3'(l), 20, 3, eMax, eGrant, eIll, eAlign);
        issue(3'(s), 3'(l), 16'd20, 5'd3);
        expectAll($sformatf("R6 R7 R8 sweep s%0d l%0d", s, l), eMax, eGrant, eIll, eAlign);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWholeGroups();
    testGrant();
    testFractions();
    testIllegalCodes();
    testAlignment();
    testHold();
    testSweep();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule